// File: doc/BRIEF.md
# SPI Hold Condition Controller

This block provides the pause function for the serial-interface side of a memory slave. It oversamples the serial clock, chip select, the active-low hold input and the serial data input with the system clock, and runs them through synchronizers. From these it derives a hold-active flag. While that flag is set, clock edges stop reaching the shift logic and the data output enable is forced off, so the pad sits at high impedance. The small receive frame inside the block (a bit counter and a shift register) keeps its contents across a pause. A transfer therefore continues from the exact bit where it stopped.

A pause may start or end only while the serial clock is low. A hold edge that arrives while the clock is high takes effect at the next falling clock edge. If the slave is deselected during a pause, the block asserts an interface reset and clears the frame. It then stays paused until the hold input is released. A pause never touches a program, erase or status-write cycle that is already running, because the block has no connection to that logic. A core sequencer sits next to this block and uses the qualified clock-edge pulses, the receive word and the interface reset.

Top module: `spi_hold_ctrl`

## Requirements
- R1: A pause can begin only while the synchronized chip select is low; a low hold input with chip select high leaves `hold_active_o` at 0.
- R2: If hold falls while the serial clock is low, the pause begins within the synchronizer latency. If it falls while the clock is high, `hold_active_o` stays 0 until the clock goes low.
- R3: If hold rises while the serial clock is low, the pause ends within the synchronizer latency. If it rises while the clock is high, `hold_active_o` stays 1 until the clock goes low.
- R4: While `hold_active_o` is 1, `sdo_oe_o` is 0 and no `sclk_rise_o` or `sclk_fall_o` pulse is produced, so clock and data input activity leaves the frame unchanged.
- R5: The bit count and the partially received word keep their values across a pause. The word completed after resuming equals the word sent before and after the pause.
- R6: Chip select going high during a pause asserts `iface_rst_o` and clears the bit count to 0. `hold_active_o` stays 1 while hold is low, even if chip select returns low.
- R7: The locked pause ends only when hold goes high, which also drops `iface_rst_o`. The next transfer starts at bit 0.
- R8: Bits are assembled MSB first on qualified rising clock edges. After WORD_W bits, `rx_valid_o` pulses for one cycle, `rx_word_o` holds the word and the bit count returns to 0. Outside a pause and while selected, `sdo_oe_o` follows `core_oe_i`.
- R9: After reset, `hold_active_o`, `iface_rst_o`, `sdo_oe_o`, `bit_cnt_o` and `rx_word_o` are all 0.
- R10: Chip select high outside a pause clears the bit count to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling system clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| sclk_i | input | 1 | Serial clock from the bus master |
| cs_n_i | input | 1 | Active-low chip select |
| hold_n_i | input | 1 | Active-low hold (pause) request |
| sdi_i | input | 1 | Serial data input |
| core_sdo_i | input | 1 | Output data bit from the core |
| core_oe_i | input | 1 | Output enable request from the core |
| hold_active_o | output | 1 | Pause in effect |
| iface_rst_o | output | 1 | Interface logic reset after a deselect during a pause |
| sclk_rise_o | output | 1 | Qualified rising serial clock edge pulse |
| sclk_fall_o | output | 1 | Qualified falling serial clock edge pulse |
| sdo_o | output | 1 | Serial data output value |
| sdo_oe_o | output | 1 | Serial data output enable (0 means high impedance) |
| bit_cnt_o | output | CNT_W | Bits received in the current word |
| rx_word_o | output | WORD_W | Last completed received word |
| rx_valid_o | output | 1 | One-cycle pulse when a word completes |

## Verification
Several behaviours are checked on every cycle by the assertions. A pause is only ever entered with the clock low and the slave selected. A normal pause exit also happens with the clock low. No edge pulse or output enable appears during a pause, and the frame count stays frozen while a pause lasts. A deselect inside a pause always leads to the interface reset on the next cycle. Other behaviours can only be shown by the bench scenarios. These are the deferral of an edge that arrives with the clock high, a word resuming correctly when the pause falls at each of the eight bit positions, and the restart from bit 0 after a locked pause.

// File: rtl/hold_pkg.sv
package hold_pkg;

  typedef enum logic [1:0] {
    HS_RUN   = 2'd0,
    HS_PAUSE = 2'd1,
    HS_LOCK  = 2'd2
  } hold_state_e;

  // Bit positions inside the synchronized input vector.
  localparam int unsigned SIG_SDI    = 0;
  localparam int unsigned SIG_HOLD_N = 1;
  localparam int unsigned SIG_CS_N   = 2;
  localparam int unsigned SIG_SCLK   = 3;
  localparam int unsigned SIG_COUNT  = 4;

  // Idle levels: clock low, deselected, hold released, data low.
  localparam logic [SIG_COUNT-1:0] SIG_IDLE = 4'b0110;

endpackage

// File: rtl/hold_sync.sv
module hold_sync #(
  parameter int unsigned       W      = 4,
  parameter int unsigned       STAGES = 2,
  parameter logic [W-1:0]      IDLE   = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] chain_q [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      logic [W-1:0] stage_d;
      if (s == 0) begin : g_first
        assign stage_d = d_i;
      end else begin : g_rest
        assign stage_d = chain_q[s-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          chain_q[s] <= IDLE;
        end else begin
          chain_q[s] <= stage_d;
        end
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/hold_fsm.sv
module hold_fsm
  import hold_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic sclk_s,
  input  logic cs_n_s,
  input  logic hold_n_s,
  output logic run_o,
  output logic hold_active_o,
  output logic iface_rst_o
);

  hold_state_e state_q, state_d;

  // Entry and normal exit are only taken while the sampled clock is low.
  // An edge that arrives with the clock high simply waits here until it is.
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      HS_RUN: begin
        if (!cs_n_s && !hold_n_s && !sclk_s) begin
          state_d = HS_PAUSE;
        end
      end
      HS_PAUSE: begin
        if (cs_n_s) begin
          state_d = HS_LOCK;
        end else if (hold_n_s && !sclk_s) begin
          state_d = HS_RUN;
        end
      end
      HS_LOCK: begin
        if (hold_n_s) begin
          state_d = HS_RUN;
        end
      end
      default: state_d = HS_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= HS_RUN;
    end else begin
      state_q <= state_d;
    end
  end

  assign run_o         = (state_q == HS_RUN);
  assign hold_active_o = (state_q != HS_RUN);
  assign iface_rst_o   = (state_q == HS_LOCK);

endmodule

// File: rtl/hold_edge.sv
module hold_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk_s,
  input  logic qual_i,
  output logic rise_o,
  output logic fall_o
);

  logic sclk_q;
  logic sclk_d;

  always_comb begin
    sclk_d = sclk_s;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= 1'b0;
    end else begin
      sclk_q <= sclk_d;
    end
  end

  assign rise_o = qual_i &  sclk_s & ~sclk_q;
  assign fall_o = qual_i & ~sclk_s &  sclk_q;

endmodule

// File: rtl/hold_frame.sv
module hold_frame #(
  parameter int unsigned WORD_W = 8,
  localparam int unsigned CNT_W = $clog2(WORD_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              shift_en_i,
  input  logic              sdi_i,
  output logic [CNT_W-1:0]  bit_cnt_o,
  output logic [WORD_W-1:0] word_o,
  output logic              valid_o
);

  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WORD_W - 1);

  logic [CNT_W-1:0]  cnt_q,  cnt_d;
  logic [WORD_W-1:0] shr_q,  shr_d;
  logic [WORD_W-1:0] word_q, word_d;
  logic              vld_q,  vld_d;
  logic              last;
  logic              word_en;

  assign last    = (cnt_q == CNT_LAST);
  assign word_en = shift_en_i & ~clr_i & last;

  always_comb begin
    cnt_d  = cnt_q;
    shr_d  = shr_q;
    word_d = word_q;
    vld_d  = 1'b0;
    if (clr_i) begin
      cnt_d = '0;
      shr_d = '0;
    end else if (shift_en_i) begin
      shr_d = {shr_q[WORD_W-2:0], sdi_i};
      cnt_d = last ? '0 : cnt_q + 1'b1;
    end
    if (word_en) begin
      word_d = {shr_q[WORD_W-2:0], sdi_i};
      vld_d  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      shr_q  <= '0;
      word_q <= '0;
      vld_q  <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      shr_q  <= shr_d;
      word_q <= word_d;
      vld_q  <= vld_d;
    end
  end

  assign bit_cnt_o = cnt_q;
  assign word_o    = word_q;
  assign valid_o   = vld_q;

endmodule

// File: rtl/spi_hold_ctrl.sv
module spi_hold_ctrl
  import hold_pkg::*;
#(
  parameter int unsigned WORD_W      = 8,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned CNT_W      = $clog2(WORD_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_i,
  input  logic              cs_n_i,
  input  logic              hold_n_i,
  input  logic              sdi_i,
  input  logic              core_sdo_i,
  input  logic              core_oe_i,
  output logic              hold_active_o,
  output logic              iface_rst_o,
  output logic              sclk_rise_o,
  output logic              sclk_fall_o,
  output logic              sdo_o,
  output logic              sdo_oe_o,
  output logic [CNT_W-1:0]  bit_cnt_o,
  output logic [WORD_W-1:0] rx_word_o,
  output logic              rx_valid_o
);

  // Reset: asserted asynchronously, released on a clock edge.
  logic [1:0] rst_pipe_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= '0;
    end else begin
      rst_pipe_q <= {rst_pipe_q[0], 1'b1};
    end
  end
  assign rst_int_n = rst_pipe_q[1];

  logic [SIG_COUNT-1:0] raw_vec, sync_vec;
  logic sclk_s, cs_n_s, hold_n_s, sdi_s;

  assign raw_vec[SIG_SDI]    = sdi_i;
  assign raw_vec[SIG_HOLD_N] = hold_n_i;
  assign raw_vec[SIG_CS_N]   = cs_n_i;
  assign raw_vec[SIG_SCLK]   = sclk_i;

  hold_sync #(
    .W      (SIG_COUNT),
    .STAGES (SYNC_STAGES),
    .IDLE   (SIG_IDLE)
  ) i_sync (
    .clk   (clk),
    .rst_n (rst_int_n),
    .d_i   (raw_vec),
    .q_o   (sync_vec)
  );

  assign sdi_s    = sync_vec[SIG_SDI];
  assign hold_n_s = sync_vec[SIG_HOLD_N];
  assign cs_n_s   = sync_vec[SIG_CS_N];
  assign sclk_s   = sync_vec[SIG_SCLK];

  logic run;
  logic pause;
  logic lock_rst;

  hold_fsm i_fsm (
    .clk           (clk),
    .rst_n         (rst_int_n),
    .sclk_s        (sclk_s),
    .cs_n_s        (cs_n_s),
    .hold_n_s      (hold_n_s),
    .run_o         (run),
    .hold_active_o (pause),
    .iface_rst_o   (lock_rst)
  );

  logic edge_qual;
  logic rise, fall;

  assign edge_qual = run & ~cs_n_s;

  hold_edge i_edge (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .sclk_s (sclk_s),
    .qual_i (edge_qual),
    .rise_o (rise),
    .fall_o (fall)
  );

  logic frame_clr;
  assign frame_clr = cs_n_s | lock_rst;

  hold_frame #(
    .WORD_W (WORD_W)
  ) i_frame (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .clr_i      (frame_clr),
    .shift_en_i (rise),
    .sdi_i      (sdi_s),
    .bit_cnt_o  (bit_cnt_o),
    .word_o     (rx_word_o),
    .valid_o    (rx_valid_o)
  );

  assign hold_active_o = pause;
  assign iface_rst_o   = lock_rst;
  assign sclk_rise_o   = rise;
  assign sclk_fall_o   = fall;
  assign sdo_o         = core_sdo_i;
  assign sdo_oe_o      = core_oe_i & ~cs_n_s & ~pause;

endmodule

// File: rtl/spi_hold_ctrl_chk.sv
module spi_hold_ctrl_chk #(
  parameter int unsigned WORD_W = 8,
  parameter int unsigned CNT_W  = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sclk_s,
  input logic             cs_n_s,
  input logic             hold_active_o,
  input logic             iface_rst_o,
  input logic             sclk_rise_o,
  input logic             sclk_fall_o,
  input logic             sdo_oe_o,
  input logic [CNT_W-1:0] bit_cnt_o,
  input logic             rx_valid_o
);

  AST_ENTRY_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hold_active_o) |-> !$past(cs_n_s)); // R1

  AST_ENTRY_CLK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hold_active_o) |-> !$past(sclk_s)); // R2

  AST_EXIT_CLK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(hold_active_o) && !$past(iface_rst_o)) |-> !$past(sclk_s)); // R3

  AST_QUIET_IN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    hold_active_o |-> (!sclk_rise_o && !sclk_fall_o && !sdo_oe_o)); // R4

  AST_FRAME_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(hold_active_o) && !iface_rst_o) |-> $stable(bit_cnt_o)); // R5

  AST_DESELECT_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_active_o && !iface_rst_o && cs_n_s) |=> iface_rst_o); // R6

  AST_WORD_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid_o |-> (bit_cnt_o == '0 && $past(bit_cnt_o) == CNT_W'(WORD_W - 1))); // R8

  AST_DESELECT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n_s |=> (bit_cnt_o == '0)); // R10

endmodule

bind spi_hold_ctrl spi_hold_ctrl_chk #(
  .WORD_W (WORD_W),
  .CNT_W  (CNT_W)
) i_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .sclk_s        (sclk_s),
  .cs_n_s        (cs_n_s),
  .hold_active_o (hold_active_o),
  .iface_rst_o   (iface_rst_o),
  .sclk_rise_o   (sclk_rise_o),
  .sclk_fall_o   (sclk_fall_o),
  .sdo_oe_o      (sdo_oe_o),
  .bit_cnt_o     (bit_cnt_o),
  .rx_valid_o    (rx_valid_o)
);

// File: tb/test_spi_hold_ctrl.sv
`timescale 1ns/1ps
module test_spi_hold_ctrl;

  localparam int unsigned WORD_W = 8;
  localparam int unsigned CNT_W  = 3;

  logic clk = 1'b0;
  logic rst_n;
  logic sclk, cs_n, hold_n, sdi, core_sdo, core_oe;
  logic hold_active, iface_rst, sclk_rise, sclk_fall, sdo, sdo_oe, rx_valid;
  logic [CNT_W-1:0]  bit_cnt;
  logic [WORD_W-1:0] rx_word;

  int checks = 0;
  int fails  = 0;
  int valid_seen = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  spi_hold_ctrl #(.WORD_W(WORD_W), .SYNC_STAGES(2)) i_spi_hold_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .sclk_i        (sclk),
    .cs_n_i        (cs_n),
    .hold_n_i      (hold_n),
    .sdi_i         (sdi),
    .core_sdo_i    (core_sdo),
    .core_oe_i     (core_oe),
    .hold_active_o (hold_active),
    .iface_rst_o   (iface_rst),
    .sclk_rise_o   (sclk_rise),
    .sclk_fall_o   (sclk_fall),
    .sdo_o         (sdo),
    .sdo_oe_o      (sdo_oe),
    .bit_cnt_o     (bit_cnt),
    .rx_word_o     (rx_word),
    .rx_valid_o    (rx_valid)
  );

  always @(posedge clk) begin
    if (rx_valid) valid_seen <= valid_seen + 1;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  // Input changes need the synchronizer plus the state register to show up.
  task automatic settle();
    repeat (8) @(negedge clk);
  endtask

  task automatic clk_bit(input logic b);
    sdi = b;
    settle();
    sclk = 1'b1;
    settle();
    sclk = 1'b0;
    settle();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      summary();
      $finish;
    end
  end

  initial begin
    logic [7:0] b;
    int vbase;
    rst_n = 1'b0; sclk = 1'b0; cs_n = 1'b1; hold_n = 1'b1; sdi = 1'b0;
    core_sdo = 1'b1; core_oe = 1'b1;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    settle();

    // R9: reset state
    chk(hold_active == 1'b0, "R9 hold_active", int'(hold_active), 0);
    chk(iface_rst == 1'b0, "R9 iface_rst", int'(iface_rst), 0);
    chk(sdo_oe == 1'b0, "R9 sdo_oe", int'(sdo_oe), 0);
    chk(bit_cnt == '0, "R9 bit_cnt", int'(bit_cnt), 0);
    chk(rx_word == '0, "R9 rx_word", int'(rx_word), 0);

    // R1: hold while deselected does nothing
    hold_n = 1'b0; settle();
    chk(hold_active == 1'b0, "R1 hold while deselected", int'(hold_active), 0);
    hold_n = 1'b1; settle();

    // R8: plain word, MSB first
    cs_n = 1'b0; settle();
    chk(sdo_oe == 1'b1, "R8 oe follows core", int'(sdo_oe), 1);
    chk(sdo == 1'b1, "R8 sdo passthrough", int'(sdo), 1);
    vbase = valid_seen;
    b = 8'hA5;
    for (int i = 0; i < 8; i++) clk_bit(b[7-i]);
    chk(rx_word == 8'hA5, "R8 word", int'(rx_word), 'hA5);
    chk(bit_cnt == '0, "R8 count wrap", int'(bit_cnt), 0);
    chk(valid_seen == vbase + 1, "R8 one valid pulse", valid_seen - vbase, 1);
    cs_n = 1'b1; settle();

    // R2/R3 deferral with clock high
    cs_n = 1'b0; settle();
    sdi = 1'b1; settle();
    sclk = 1'b1; settle();
    chk(bit_cnt == 3'd1, "R8 first bit", int'(bit_cnt), 1);
    hold_n = 1'b0; settle();
    chk(hold_active == 1'b0, "R2 deferred entry", int'(hold_active), 0);
    sclk = 1'b0; settle();
    chk(hold_active == 1'b1, "R2 entry on clock low", int'(hold_active), 1);
    chk(sdo_oe == 1'b0, "R4 oe off in hold", int'(sdo_oe), 0);
    clk_bit(1'b0);
    clk_bit(1'b1);
    chk(bit_cnt == 3'd1, "R4 clocks ignored", int'(bit_cnt), 1);
    sclk = 1'b1; settle();
    hold_n = 1'b1; settle();
    chk(hold_active == 1'b1, "R3 deferred exit", int'(hold_active), 1);
    sclk = 1'b0; settle();
    chk(hold_active == 1'b0, "R3 exit on clock low", int'(hold_active), 0);
    chk(bit_cnt == 3'd1, "R5 count kept", int'(bit_cnt), 1);
    cs_n = 1'b1; settle();
    chk(bit_cnt == '0, "R10 deselect clears", int'(bit_cnt), 0);

    // R5: pause inserted before every bit position
    for (int p = 0; p < 8; p++) begin
      b = 8'h3C ^ 8'(p * 37);
      cs_n = 1'b0; settle();
      for (int i = 0; i < 8; i++) begin
        if (i == p) begin
          hold_n = 1'b0; settle();
          chk(hold_active == 1'b1, "R2 immediate entry", int'(hold_active), 1);
          for (int j = 0; j < 3; j++) clk_bit(~b[7-i]);
          chk(bit_cnt == CNT_W'(p), "R5 count frozen", int'(bit_cnt), p);
          chk(sdo_oe == 1'b0, "R4 high impedance", int'(sdo_oe), 0);
          hold_n = 1'b1; settle();
          chk(hold_active == 1'b0, "R3 immediate exit", int'(hold_active), 0);
        end
        clk_bit(b[7-i]);
      end
      chk(rx_word == b, "R5 resumed word", int'(rx_word), int'(b));
      cs_n = 1'b1; settle();
      chk(bit_cnt == '0, "R10 frame end", int'(bit_cnt), 0);
    end

    // R6/R7: deselect during a pause
    cs_n = 1'b0; settle();
    clk_bit(1'b1); clk_bit(1'b0); clk_bit(1'b1);
    chk(bit_cnt == 3'd3, "R6 partial count", int'(bit_cnt), 3);
    hold_n = 1'b0; settle();
    cs_n = 1'b1; settle();
    chk(iface_rst == 1'b1, "R6 iface reset", int'(iface_rst), 1);
    chk(hold_active == 1'b1, "R6 still paused", int'(hold_active), 1);
    chk(bit_cnt == '0, "R6 count cleared", int'(bit_cnt), 0);
    cs_n = 1'b0; settle();
    chk(hold_active == 1'b1, "R6 paused after reselect", int'(hold_active), 1);
    clk_bit(1'b1);
    chk(bit_cnt == '0, "R6 clocks ignored in lock", int'(bit_cnt), 0);
    hold_n = 1'b1; settle();
    chk(iface_rst == 1'b0, "R7 reset released", int'(iface_rst), 0);
    chk(hold_active == 1'b0, "R7 pause ended", int'(hold_active), 0);
    b = 8'h96;
    for (int i = 0; i < 8; i++) clk_bit(b[7-i]);
    chk(rx_word == 8'h96, "R7 restart from bit 0", int'(rx_word), 'h96);
    cs_n = 1'b1; settle();

    done = 1'b1;
    summary();
    $finish;
  end

endmodule